// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block decides when a small processor core runs, idles or sleeps. It decodes a one-bit mode state into clock enables for the instruction clock, the oscillator, the timer/counter, the watchdog and the interrupt logic. It also drives an internal reset and a strobe/reset status line. A halt strobe from the CPU parks the core in standby, where everything but the instruction clock keeps running. An enabled interrupt request brings the core back to run. Standby is mode 1 of the encoding given in R10.

Deep sleep stops every clock. Software enters it through a sleep-request write, and that write is honoured only after a separate arm bit has been set. The only way out of sleep is the external reset pin. The pin must be held high long enough to count, and the block then holds the core in reset while the oscillator is given a fixed number of cycles to start.

The arm bit is not cleared by the pin reset. Software can therefore read it after start-up: 1 means the core woke from sleep, and 0 means a cold power-up.

Top module: `lp_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, the block is in the start-up hold (mode 3) with `mask_o`=0 and `sleep_flag_o`=0. It reaches run (mode 0) after exactly OSC_WAIT rising clock edges counted from the release.
- R2: The outputs depend on the mode as follows. In run, all five enables are 1. In standby, every enable except `cpu_clk_en_o` is 1. In sleep, all enables are 0. In the start-up hold, only `osc_en_o` is 1.
- R3: When `halt_i` is high in run, the mode is standby (1) one cycle later, and `mask_o` keeps its value.
- R4: Standby moves to run one cycle after a cycle in which some bit has both `irq_req_i` and `irq_en_i` set. Request bits whose enable is 0 leave the block in standby.
- R5: When `halt_i` and an enabled interrupt arrive in the same run cycle, the block stays in run.
- R6: `mask_wr_i` loads `mask_val_i` into the arm bit, and this happens only in run. In run, `sleep_wr_i` moves the block to sleep (mode 2) and sets `sleep_flag_o` to 1 one cycle later, but only if the arm bit was already 1. If the arm bit is 0, the write is ignored. A sleep request takes priority over `halt_i`.
- R7: In sleep, interrupts, `halt_i`, `mask_wr_i` and `sleep_wr_i` have no effect.
- R8: `ext_rst_i` counts as a reset only when it is high for RST_MIN consecutive clock edges. On the edge that samples it high for the RST_MIN-th time, the block enters the start-up hold, whatever mode it was in. Shorter pulses change nothing.
- R9: The start-up hold lasts OSC_WAIT cycles, with `int_rst_o`=1 and `strobe_o`=1 throughout, and then the block returns to run. Entering the hold clears `sleep_flag_o` and leaves `mask_o` unchanged.
- R10: `mode_o` encodes the modes as run=0, standby=1, sleep=2 and start-up hold=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| halt_i | input | 1 | Halt strobe from the CPU |
| mask_wr_i | input | 1 | Write strobe for the sleep arm bit |
| mask_val_i | input | 1 | Value written to the arm bit |
| sleep_wr_i | input | 1 | Sleep request write |
| irq_req_i | input | N_IRQ | Interrupt requests |
| irq_en_i | input | N_IRQ | Interrupt enables |
| ext_rst_i | input | 1 | External reset pin, active high |
| cpu_clk_en_o | output | 1 | Instruction clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| tmr_clk_en_o | output | 1 | Timer/counter clock enable |
| wdt_clk_en_o | output | 1 | Watchdog clock enable |
| irq_clk_en_o | output | 1 | Interrupt logic clock enable |
| int_rst_o | output | 1 | Internal reset to the core |
| strobe_o | output | 1 | Strobe/reset status output |
| mask_o | output | 1 | Sleep arm bit, read back |
| sleep_flag_o | output | 1 | Sleep flag, read back |
| mode_o | output | 2 | Current mode (R10) |

## Verification
Every output is decoded from registered state. A stimulus sampled at a rising edge therefore shows up at the outputs one cycle later. The two exceptions are the reset pin, which takes effect only on its RST_MIN-th consecutive high edge, and the start-up hold, which ends exactly OSC_WAIT edges after it begins. The bench drives its inputs on the falling edge and advances a behavioural model on the rising edge. On the next falling edge it compares every output against that model, so each result is read in the cycle it is due. Directed checks also count the edges spent in the hold and the edges spent qualifying the reset pin.

// File: rtl/lp_mode_pkg.sv
package lp_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_STBY  = 2'd1,
    MODE_SLEEP = 2'd2,
    MODE_WAKE  = 2'd3
  } lp_mode_e;
endpackage

// File: rtl/lp_rst_qual.sv
module lp_rst_qual #(
  parameter int RST_MIN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic valid_o
);
  localparam int CW = $clog2(RST_MIN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  // consecutive-high counter, saturates so a held pin fires once
  always_comb begin
    if (!pin_i) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(RST_MIN)) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign valid_o = pin_i && (cnt_q == CW'(RST_MIN - 1));

  // R8
  rst_one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8
  rst_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(RST_MIN));
endmodule

// File: rtl/lp_wake_timer.sv
module lp_wake_timer #(
  parameter int OSC_WAIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic restart_i,
  output logic done_o
);
  localparam int CW = $clog2(OSC_WAIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = active_i && !restart_i && (cnt_q == CW'(OSC_WAIT - 1));

  always_comb begin
    if (restart_i || !active_i) begin
      cnt_d = '0;
    end else if (done_o) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R9
  wake_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> cnt_q < CW'(OSC_WAIT));
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lp_mode_pkg::*;
#(
  parameter int N_IRQ    = 4,
  parameter int RST_MIN  = 8,
  parameter int OSC_WAIT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             mask_wr_i,
  input  logic             mask_val_i,
  input  logic             sleep_wr_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             ext_rst_i,
  output logic             cpu_clk_en_o,
  output logic             osc_en_o,
  output logic             tmr_clk_en_o,
  output logic             wdt_clk_en_o,
  output logic             irq_clk_en_o,
  output logic             int_rst_o,
  output logic             strobe_o,
  output logic             mask_o,
  output logic             sleep_flag_o,
  output logic [1:0]       mode_o
);
  lp_mode_e state_q, state_d;
  logic     mask_q, mask_d;
  logic     flag_q, flag_d;
  logic     rst_valid;
  logic     wake_done;
  logic     irq_hit;

  assign irq_hit = |(irq_req_i & irq_en_i);

  lp_rst_qual #(.RST_MIN(RST_MIN)) u_rst_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_rst_i),
    .valid_o(rst_valid)
  );

  lp_wake_timer #(.OSC_WAIT(OSC_WAIT)) u_wake_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (state_q == MODE_WAKE),
    .restart_i(rst_valid),
    .done_o   (wake_done)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    flag_d  = flag_q;
    if (rst_valid) begin
      state_d = MODE_WAKE;
      flag_d  = 1'b0;
    end else begin
      unique case (state_q)
        MODE_RUN: begin
          if (mask_wr_i) begin
            mask_d = mask_val_i;
          end
          if (sleep_wr_i && mask_q) begin
            state_d = MODE_SLEEP;
            flag_d  = 1'b1;
          end else if (halt_i && !irq_hit) begin
            state_d = MODE_STBY;
          end
        end
        MODE_STBY: begin
          if (irq_hit) begin
            state_d = MODE_RUN;
          end
        end
        MODE_SLEEP: begin
          state_d = MODE_SLEEP;
        end
        MODE_WAKE: begin
          if (wake_done) begin
            state_d = MODE_RUN;
          end
        end
        default: state_d = MODE_WAKE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MODE_WAKE;
      mask_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
      flag_q  <= flag_d;
    end
  end

  // output decode
  assign cpu_clk_en_o = (state_q == MODE_RUN);
  assign osc_en_o     = (state_q != MODE_SLEEP);
  assign tmr_clk_en_o = (state_q == MODE_RUN) || (state_q == MODE_STBY);
  assign wdt_clk_en_o = (state_q == MODE_RUN) || (state_q == MODE_STBY);
  assign irq_clk_en_o = (state_q == MODE_RUN) || (state_q == MODE_STBY);
  assign int_rst_o    = (state_q == MODE_WAKE);
  assign strobe_o     = (state_q == MODE_WAKE);
  assign mask_o       = mask_q;
  assign sleep_flag_o = flag_q;
  assign mode_o       = state_q;

  // R6
  sleep_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == MODE_SLEEP) |-> $past(mask_q));

  // R7
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_SLEEP) && !rst_valid |=> (state_q == MODE_SLEEP));

  // R4
  stby_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_STBY) && !irq_hit && !rst_valid |=> (state_q == MODE_STBY));

  // R9
  mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != MODE_RUN) |=> (mask_q == $past(mask_q)));

  // R5
  halt_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_RUN) && halt_i && irq_hit && !sleep_wr_i && !rst_valid
    |=> (state_q == MODE_RUN));

  // R9
  wake_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done |=> (state_q == MODE_RUN));
endmodule

// File: tb/lp_mode_ctrl_test.sv
module lp_mode_ctrl_test;
  localparam int N_IRQ    = 4;
  localparam int RST_MIN  = 8;
  localparam int OSC_WAIT = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic halt, mask_wr, mask_val, sleep_wr, ext_rst;
  logic [N_IRQ-1:0] irq_req, irq_en;
  logic cpu_en, osc_en, tmr_en, wdt_en, irq_cen, int_rst, strobe, mask, flag;
  logic [1:0] mode;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference state
  int m_mode, m_mask, m_flag, m_hi, m_wait;

  always #10 clk = ~clk;

  lp_mode_ctrl #(.N_IRQ(N_IRQ), .RST_MIN(RST_MIN), .OSC_WAIT(OSC_WAIT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .mask_wr_i(mask_wr),
    .mask_val_i(mask_val), .sleep_wr_i(sleep_wr), .irq_req_i(irq_req),
    .irq_en_i(irq_en), .ext_rst_i(ext_rst), .cpu_clk_en_o(cpu_en),
    .osc_en_o(osc_en), .tmr_clk_en_o(tmr_en), .wdt_clk_en_o(wdt_en),
    .irq_clk_en_o(irq_cen), .int_rst_o(int_rst), .strobe_o(strobe),
    .mask_o(mask), .sleep_flag_o(flag), .mode_o(mode)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 3; m_mask = 0; m_flag = 0; m_hi = 0; m_wait = 0;
    end else begin
      bit fire, hit;
      fire = ext_rst && (m_hi == RST_MIN - 1);
      m_hi = ext_rst ? ((m_hi < RST_MIN) ? m_hi + 1 : m_hi) : 0;
      hit = (irq_req & irq_en) != 0;
      if (fire) begin
        m_mode = 3; m_wait = 0; m_flag = 0;
      end else if (m_mode == 0) begin
        int old_mask;
        old_mask = m_mask;
        if (mask_wr) m_mask = mask_val;
        if (sleep_wr && old_mask == 1) begin
          m_mode = 2; m_flag = 1;
        end else if (halt && !hit) begin
          m_mode = 1;
        end
      end else if (m_mode == 1) begin
        if (hit) m_mode = 0;
      end else if (m_mode == 3) begin
        if (m_wait == OSC_WAIT - 1) m_mode = 0;
        else m_wait++;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R10 mode", mode, m_mode);
    chk("R2 cpu_en", cpu_en, m_mode == 0);
    chk("R2 osc_en", osc_en, m_mode != 2);
    chk("R2 tmr_en", tmr_en, m_mode <= 1);
    chk("R2 wdt_en", wdt_en, m_mode <= 1);
    chk("R2 irq_en", irq_cen, m_mode <= 1);
    chk("R9 int_rst", int_rst, m_mode == 3);
    chk("R9 strobe", strobe, m_mode == 3);
    chk("R6 mask", mask, m_mask);
    chk("R6 flag", flag, m_flag);
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic idle();
    halt = 0; mask_wr = 0; mask_val = 0; sleep_wr = 0;
    irq_req = '0; irq_en = '0;
  endtask

  task automatic wait_run(string tag);
    int n = 0;
    while (mode != 2'd0 && n < 100) begin
      cyc(1);
      n++;
    end
    chk(tag, n, OSC_WAIT);
  endtask

  initial begin
    rst_n = 0; ext_rst = 0; idle();
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 3);
    chk("R1 mask", mask, 0);
    chk("R1 flag", flag, 0);
    chk("R1 int_rst", int_rst, 1);
    rst_n = 1;
    wait_run("R1 hold length");

    // R3 halt to standby
    halt = 1; cyc(1); halt = 0;
    chk("R3 standby", mode, 1);
    // R4 disabled requests ignored
    irq_req = 4'b0101; irq_en = 4'b1010; cyc(5);
    chk("R4 disabled", mode, 1);
    irq_en = 4'b0001; cyc(1); idle();
    chk("R4 wake irq", mode, 0);

    // R5 halt with enabled irq
    halt = 1; irq_req = 4'b1000; irq_en = 4'b1000; cyc(1); idle();
    chk("R5 stay run", mode, 0);

    // R6 unarmed sleep write ignored, then armed
    sleep_wr = 1; cyc(1); idle();
    chk("R6 unarmed", mode, 0);
    mask_wr = 1; mask_val = 1; cyc(1); idle();
    chk("R6 arm", mask, 1);
    sleep_wr = 1; halt = 1; cyc(1); idle();
    chk("R6 sleep", mode, 2);
    chk("R6 flag", flag, 1);

    // R7 everything but the pin ignored in sleep
    irq_req = '1; irq_en = '1; halt = 1; mask_wr = 1; mask_val = 0; sleep_wr = 1;
    cyc(4); idle();
    chk("R7 still sleep", mode, 2);
    chk("R7 mask kept", mask, 1);
    chk("R7 osc off", osc_en, 0);

    // R8 short pulse rejected
    ext_rst = 1; cyc(RST_MIN - 1); ext_rst = 0; cyc(2);
    chk("R8 short pulse", mode, 2);
    // R8 full pulse wakes
    ext_rst = 1; cyc(RST_MIN);
    chk("R8 qualified", mode, 3);
    chk("R9 strobe", strobe, 1);
    chk("R9 flag clr", flag, 0);
    chk("R9 mask kept", mask, 1);
    wait_run("R9 hold length");
    ext_rst = 0; cyc(1);
    chk("R9 woke from sleep", mask, 1);

    // R8 pin reset from standby
    halt = 1; cyc(1); idle();
    ext_rst = 1; cyc(RST_MIN); ext_rst = 0;
    chk("R8 from standby", mode, 3);
    wait_run("R9 hold length 2");

    // R6 disarm then sleep write ignored
    mask_wr = 1; mask_val = 0; cyc(1); idle();
    sleep_wr = 1; cyc(1); idle(); cyc(2);
    chk("R6 disarmed", mode, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule